// File: doc/BRIEF.md
# Two-Way Latched and Registered Bus Transceiver

This block moves an 18-bit word between two buses, A and B, in two independent paths. The A-to-B path carries `a_in` to `b_out`, and the B-to-A path carries `b_in` to `a_out`. Each path has one storage word that works in one of two ways, chosen by that path's latch-enable:

- **Transparent:** when the latch-enable is high, the output follows the input.
- **Opaque:** when the latch-enable is low, the path holds its word. It takes in a new word only when its path clock has a high-to-low transition.

The block runs from one system clock. The path clocks are treated as ordinary data signals. Each is passed through a two-flop synchroniser, and its falling edge is detected with a plain compare, so no clock is ever gated.

Each side does not have a true tri-state pin. Instead it has a data bus plus a one-bit drive flag. Whatever sits at the pad level can turn that pair into a tri-state driver.

The two drive flags use opposite polarities. The A-to-B enable is active high. The B-to-A enable is active low. While a side is not driven, its data bus is forced to all zeros, so no stale value leaks out.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: During a synchronous active-high `rst`, both storage words are cleared. After reset, with the latch-enables low and both sides driven, both data outputs read 0.
- R2: While a path's latch-enable is high, its output equals its input in the same system cycle.
- R3: While a path's latch-enable is low and its path clock holds a steady level, the output keeps its value, whatever the input does.
- R4: While the latch-enable is low, a path-clock fall captures the input. The path clock is first seen low at system clock edge k. The input present at edge k+2 then appears on the output after edge k+2. A rising path clock captures nothing.
- R5: Suppose the latch-enable drops while the path clock is low, and the path clock stays low. The output then keeps the last value it passed through in transparent mode.
- R6: `b_drive` is 1 exactly when `ab_oe` is 1 (the A-to-B enable is active high).
- R7: `a_drive` is 1 exactly when `ba_oe_n` is 0 (the B-to-A enable is active low).
- R8: While a side's drive flag is 0, that side's data bus reads all zeros. While the flag is 1, the bus carries the path value.
- R9: The two paths are independent. Activity on one path's inputs and controls never changes the other path's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Word arriving from side A |
| b_in | input | 18 | Word arriving from side B |
| ab_le | input | 1 | A-to-B latch-enable (1 = transparent) |
| ab_clk | input | 1 | A-to-B path clock, captured on its fall |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ba_le | input | 1 | B-to-A latch-enable (1 = transparent) |
| ba_clk | input | 1 | B-to-A path clock, captured on its fall |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| b_out | output | 18 | Word driven onto side B, zero when not driven |
| b_drive | output | 1 | Side B drive flag |
| a_out | output | 18 | Word driven onto side A, zero when not driven |
| a_drive | output | 1 | Side A drive flag |

## Verification
The hardest case to reach is a capture whose timing has to be exact. A path-clock fall has to arrive while the latch-enable is low, with no pending synchroniser edge left over from transparent mode. The check must also show that the input present on the third system clock edge is taken, and not an earlier or later one. Directed sequences therefore settle the synchroniser for several cycles before each fall. The input is changed on every cycle around the fall, so a one-cycle error in latency shows up as a wrong word. A seeded random phase then toggles the latch-enables, path clocks and enables at mixed rates. It compares both sides every cycle against a cycle model in the bench.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_WIDTH  = 18;
    localparam int unsigned SYNC_DEPTH  = 2;
    localparam int unsigned NUM_PATHS   = 2;

    typedef enum logic [0:0] {
        PATH_AB = 1'b0,
        PATH_BA = 1'b1
    } path_id_e;

    typedef struct packed {
        logic le;
        logic pclk;
        logic oe_pin;
    } path_ctl_t;

    function automatic logic enable_level(input logic pin, input logic active_low);
        return active_low ? ~pin : pin;
    endfunction

endpackage

// File: rtl/clk_edge_sync.sv
module clk_edge_sync #(
    parameter int unsigned STAGES = xcvr_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic pclk,
    output logic fall
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], pclk};
        end
    end

    // previous synchronised sample high, current synchronised sample low
    assign fall = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];

endmodule

// File: rtl/path_store.sv
module path_store #(
    parameter int unsigned W = xcvr_pkg::XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic         fall,
    input  logic [W-1:0] din,
    output logic [W-1:0] view
);
    logic [W-1:0] held_q;
    logic         load;

    // tracking while transparent keeps the word steady when le drops
    assign load = le | fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= din;
        end
    end

    assign view = le ? din : held_q;

endmodule

// File: rtl/drive_gate.sv
module drive_gate #(
    parameter int unsigned W          = xcvr_pkg::XCVR_WIDTH,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input  logic         oe_pin,
    input  logic [W-1:0] value,
    output logic [W-1:0] dout,
    output logic         drive
);
    assign drive = xcvr_pkg::enable_level(oe_pin, ACTIVE_LOW);
    assign dout  = drive ? value : '0;
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W     = XCVR_WIDTH,
    parameter int unsigned SYNCS = SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ab_oe,
    input  logic         ba_le,
    input  logic         ba_clk,
    input  logic         ba_oe_n,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic [W-1:0] a_out,
    output logic         a_drive
);
    path_ctl_t          ctl   [NUM_PATHS];
    logic [W-1:0]       src   [NUM_PATHS];
    logic [W-1:0]       dst   [NUM_PATHS];
    logic               drv   [NUM_PATHS];

    assign ctl[PATH_AB] = '{le: ab_le, pclk: ab_clk, oe_pin: ab_oe};
    assign ctl[PATH_BA] = '{le: ba_le, pclk: ba_clk, oe_pin: ba_oe_n};
    assign src[PATH_AB] = a_in;
    assign src[PATH_BA] = b_in;

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        logic         fall;
        logic [W-1:0] view;

        clk_edge_sync #(.STAGES(SYNCS)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .pclk (ctl[g].pclk),
            .fall (fall)
        );

        path_store #(.W(W)) u_store (
            .clk  (clk),
            .rst  (rst),
            .le   (ctl[g].le),
            .fall (fall),
            .din  (src[g]),
            .view (view)
        );

        drive_gate #(.W(W), .ACTIVE_LOW(g == int'(PATH_BA))) u_gate (
            .oe_pin (ctl[g].oe_pin),
            .value  (view),
            .dout   (dst[g]),
            .drive  (drv[g])
        );
    end

    assign b_out   = dst[PATH_AB];
    assign b_drive = drv[PATH_AB];
    assign a_out   = dst[PATH_BA];
    assign a_drive = drv[PATH_BA];

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_le,
    input logic         ab_clk,
    input logic         ab_oe,
    input logic         ba_le,
    input logic         ba_clk,
    input logic         ba_oe_n,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic [W-1:0] a_out,
    input logic         a_drive
);
    a_r6_b_drive_pol: assert property (@(posedge clk) disable iff (rst)
        b_drive == ab_oe);

    a_r7_a_drive_pol: assert property (@(posedge clk) disable iff (rst)
        a_drive == !ba_oe_n);

    a_r8_b_quiet: assert property (@(posedge clk) disable iff (rst)
        !b_drive |-> (b_out == '0));

    a_r8_a_quiet: assert property (@(posedge clk) disable iff (rst)
        !a_drive |-> (a_out == '0));

    a_r2_ab_transparent: assert property (@(posedge clk) disable iff (rst)
        (ab_le && ab_oe) |-> (b_out == a_in));

    a_r2_ba_transparent: assert property (@(posedge clk) disable iff (rst)
        (ba_le && !ba_oe_n) |-> (a_out == b_in));

    a_r3_ab_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !ab_le && !$past(ab_le) && !$past(ab_le, 2)
         && ab_oe && $past(ab_oe)
         && ab_clk == $past(ab_clk) && ab_clk == $past(ab_clk, 2)
         && ab_clk == $past(ab_clk, 3) && ab_clk == $past(ab_clk, 4))
        |-> $stable(b_out));

    a_r3_ba_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !ba_le && !$past(ba_le) && !$past(ba_le, 2)
         && !ba_oe_n && !$past(ba_oe_n)
         && ba_clk == $past(ba_clk) && ba_clk == $past(ba_clk, 2)
         && ba_clk == $past(ba_clk, 3) && ba_clk == $past(ba_clk, 4))
        |-> $stable(a_out));

endmodule

bind bidir_latch_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .b_in    (b_in),
    .ab_le   (ab_le),
    .ab_clk  (ab_clk),
    .ab_oe   (ab_oe),
    .ba_le   (ba_le),
    .ba_clk  (ba_clk),
    .ba_oe_n (ba_oe_n),
    .b_out   (b_out),
    .b_drive (b_drive),
    .a_out   (a_out),
    .a_drive (a_drive)
);

// File: tb/bidir_latch_xcvr_tb.sv
module bidir_latch_xcvr_tb;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe_n;
    logic [W-1:0] b_out, a_out;
    logic         b_drive, a_drive;

    int checks   = 0;
    int failures = 0;

    // bench cycle model: index 0 = A-to-B, 1 = B-to-A
    logic         m_s1 [2];
    logic         m_s2 [2];
    logic         m_s3 [2];
    logic [W-1:0] m_held [2];

    always #2 clk = ~clk;

    bidir_latch_xcvr u_dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
        .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    function automatic logic path_le(input int d);
        return (d == 0) ? ab_le : ba_le;
    endfunction

    function automatic logic [W-1:0] path_in(input int d);
        return (d == 0) ? a_in : b_in;
    endfunction

    function automatic logic exp_drive(input int d);
        return (d == 0) ? ab_oe : ~ba_oe_n;
    endfunction

    function automatic logic [W-1:0] exp_data(input int d);
        if (!exp_drive(d)) return '0;
        return path_le(d) ? path_in(d) : m_held[d];
    endfunction

    task automatic cycle();
        logic         n_s1 [2];
        logic         n_s2 [2];
        logic         n_s3 [2];
        logic [W-1:0] n_held [2];
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                n_s1[d] = 1'b0; n_s2[d] = 1'b0; n_s3[d] = 1'b0; n_held[d] = '0;
            end else begin
                n_held[d] = (path_le(d) || (m_s3[d] && !m_s2[d])) ? path_in(d) : m_held[d];
                n_s3[d] = m_s2[d];
                n_s2[d] = m_s1[d];
                n_s1[d] = (d == 0) ? ab_clk : ba_clk;
            end
        end
        @(posedge clk);
        for (int d = 0; d < 2; d++) begin
            m_s1[d] = n_s1[d]; m_s2[d] = n_s2[d]; m_s3[d] = n_s3[d]; m_held[d] = n_held[d];
        end
        #1;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic check_eq(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_model(input string tag);
        check_eq({tag, " R6 b_drive"}, {17'd0, b_drive}, {17'd0, exp_drive(0)});
        check_eq({tag, " R7 a_drive"}, {17'd0, a_drive}, {17'd0, exp_drive(1)});
        check_eq({tag, " R8 b_out"},   b_out, exp_data(0));
        check_eq({tag, " R8 a_out"},   a_out, exp_data(1));
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] keep_b;
        logic [W-1:0] keep_a;
        void'($urandom(32'h1D5E_7A11));
        for (int d = 0; d < 2; d++) begin
            m_s1[d] = 1'b0; m_s2[d] = 1'b0; m_s3[d] = 1'b0; m_held[d] = '0;
        end
        rst = 1'b1; a_in = 18'h2A5A5; b_in = 18'h15A5A;
        ab_le = 1'b0; ab_clk = 1'b0; ab_oe = 1'b1;
        ba_le = 1'b0; ba_clk = 1'b0; ba_oe_n = 1'b0;
        @(negedge clk);
        cycles(3);
        rst = 1'b0;
        cycles(1);
        check_eq("R1 reset b_out", b_out, '0);
        check_eq("R1 reset a_out", a_out, '0);

        // R2 transparent, same cycle
        ab_le = 1'b1; a_in = 18'h0BEEF; #1;
        check_eq("R2 ab transparent", b_out, 18'h0BEEF);
        ba_le = 1'b1; b_in = 18'h3C3C3; #1;
        check_eq("R2 ba transparent", a_out, 18'h3C3C3);
        cycles(4);

        // R5 latch-enable drops with path clock low and staying low
        ab_le = 1'b0; a_in = 18'h11111; #1;
        check_eq("R5 ab keeps last transparent word", b_out, 18'h0BEEF);
        ba_le = 1'b0; b_in = 18'h22222; #1;
        check_eq("R5 ba keeps last transparent word", a_out, 18'h3C3C3);

        // R3 hold with steady path clock while inputs churn
        for (int i = 0; i < 6; i++) begin
            cycle();
            a_in = 18'($urandom); b_in = 18'($urandom);
        end
        #1;
        check_eq("R3 ab hold", b_out, 18'h0BEEF);
        check_eq("R3 ba hold", a_out, 18'h3C3C3);

        // R4 rising path clock captures nothing
        ab_clk = 1'b1; a_in = 18'h01234;
        cycles(5);
        check_eq("R4 rise no capture", b_out, 18'h0BEEF);

        // R4 exact latency of a falling capture
        ab_clk = 1'b0; a_in = 18'h0AAAA;
        cycle(); a_in = 18'h0BBBB;
        cycle(); a_in = 18'h0CCCC;
        check_eq("R4 unchanged before capture", b_out, 18'h0BEEF);
        cycle(); a_in = 18'h0DDDD; #1;
        check_eq("R4 capture on third edge", b_out, 18'h0CCCC);
        cycles(3);
        check_eq("R4 stays after capture", b_out, 18'h0CCCC);

        // R9 heavy A-to-B activity leaves B-to-A untouched
        for (int i = 0; i < 20; i++) begin
            ab_clk = ~ab_clk; ab_le = 1'($urandom); a_in = 18'($urandom);
            cycle();
        end
        check_eq("R9 a_out untouched by ab path", a_out, 18'h3C3C3);
        keep_b = b_out;
        ab_le = 1'b0;
        ab_clk = 1'b0;
        cycles(5);
        keep_b = b_out;
        for (int i = 0; i < 20; i++) begin
            ba_clk = ~ba_clk; ba_le = 1'($urandom); b_in = 18'($urandom);
            cycle();
        end
        check_eq("R9 b_out untouched by ba path", b_out, keep_b);

        // R6 R7 R8 enables and quiet buses
        keep_a = a_out;
        ab_oe = 1'b0; ba_oe_n = 1'b1; #1;
        check_eq("R6 b_drive low when ab_oe=0", {17'd0, b_drive}, 18'd0);
        check_eq("R7 a_drive low when ba_oe_n=1", {17'd0, a_drive}, 18'd0);
        check_eq("R8 b_out zero when undriven", b_out, '0);
        check_eq("R8 a_out zero when undriven", a_out, '0);
        ab_oe = 1'b1; ba_oe_n = 1'b0; #1;
        check_eq("R6 b_drive high when ab_oe=1", {17'd0, b_drive}, 18'd1);
        check_eq("R7 a_drive high when ba_oe_n=0", {17'd0, a_drive}, 18'd1);
        check_eq("R8 b_out restored", b_out, keep_b);
        check_eq("R8 a_out restored", a_out, keep_a);

        // random phase against the cycle model
        for (int i = 0; i < 600; i++) begin
            cycle();
            if ($urandom_range(7) == 0) ab_le = ~ab_le;
            if ($urandom_range(7) == 0) ba_le = ~ba_le;
            if ($urandom_range(2) == 0) ab_clk = ~ab_clk;
            if ($urandom_range(3) == 0) ba_clk = ~ba_clk;
            if ($urandom_range(9) == 0) ab_oe = ~ab_oe;
            if ($urandom_range(9) == 0) ba_oe_n = ~ba_oe_n;
            a_in = 18'($urandom);
            b_in = 18'($urandom);
            #1;
            check_model("random R2 R3 R4");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule